// File: doc/BRIEF.md
# E1-to-T1 Channel Mapper

This block takes a serial 2.048 Mb/s system-side stream organised as 32 timeslots of 8 bits and rebuilds it in the 24-channel T1 layout used on the line side. Bits arrive one per strobe with a per-bit signaling stream and a frame sync pulse. A programmable offset, given as whole timeslots plus extra bits, separates the sync pulse from the first bit of the frame. The mapper counts bit positions from that point, assembles each timeslot, and marks every finished slot that belongs in the T1 frame.

The continuous-channels scheme is implemented. Timeslots 1 through 24 become channels 1 through 24, in that order. The T1 F-bit is the last bit of timeslot 0. The rest of timeslot 0 and all of timeslots 25 to 31 are dropped. Each frame therefore yields 193 output bits: one F-bit strobe and 24 channel strobes. Each channel strobe carries the channel's four signaling bits, which stay aligned to its data. A 2-bit scheme selector is present, but every code maps continuously.

Top module: `e1t1_mapper`

## Requirements
- R1: After reset, `ch_valid` and `fbit_valid` stay low until a sync pulse has been taken on a cycle with `bit_en` high.
- R2: A high `sync_in` on a cycle with `bit_en` low is ignored. It neither starts nor realigns a frame.
- R3: With a timeslot offset C (`chan_off`) and a bit offset B (`bit_off`) sampled on the sync strobe, frame bit 0 is the bit taken C*8+B strobes after the sync strobe. With C and B both zero, frame bit 0 is the bit taken on the sync strobe itself. Frame bit k belongs to timeslot k/8.
- R4: On the cycle after the 8th bit of timeslot 0 (frame bit 7) is taken, `fbit_valid` is high for one cycle and `fbit` equals that bit. The first 7 bits of timeslot 0 produce no strobe.
- R5: On the cycle after the 8th bit of timeslot n (1..24) is taken, `ch_valid` is high for one cycle, `ch_num` equals n, and `ch_data` holds the slot's bits with the first received bit in bit 7.
- R6: `ch_sig` holds the `e1_sig` values taken with bits 5 to 8 of the timeslot. Bit 5 goes to `ch_sig[3]` and bit 8 goes to `ch_sig[0]`.
- R7: Timeslots 25 to 31 produce no strobe.
- R8: Without further sync pulses, the 256-bit frame cadence continues from the last alignment.
- R9: A sync pulse in the middle of a frame realigns frame position from that strobe on.
- R10: `map_mode` codes 0 (standard recommendation), 1 (one filler every four channels), 2 (continuous) and 3 (reserved) all produce the continuous mapping.
- R11: At most one of `ch_valid` and `fbit_valid` is high in any cycle. `ch_num`, `ch_data`, `ch_sig` and `fbit` read zero when their strobe is low.
- R12: Cycles with `bit_en` low advance nothing, and no strobe appears on the cycle after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit strobe: the input bit is taken this cycle |
| e1_bit | input | 1 | System-side data bit |
| e1_sig | input | 1 | System-side signaling bit, aligned with `e1_bit` |
| sync_in | input | 1 | Frame sync pulse, qualified by `bit_en` |
| chan_off | input | 5 | Offset in whole timeslots |
| bit_off | input | 3 | Additional offset in bits |
| map_mode | input | 2 | Rate-mapping scheme code |
| ch_valid | output | 1 | T1 channel byte ready |
| ch_num | output | 5 | T1 channel number 1..24 |
| ch_data | output | 8 | Channel byte, first received bit in bit 7 |
| ch_sig | output | 4 | Channel signaling bits |
| fbit_valid | output | 1 | T1 F-bit ready |
| fbit | output | 1 | T1 F-bit value |

## Verification
Every result is due on the cycle right after the clock edge that takes the 8th bit of a slot. Two registers sit on that path, the slot position and the assembled byte, and both update on that same edge. The bench drives inputs on the falling edge. At the same falling edge it first compares the outputs with what its behavioural model predicted from the inputs of the previous cycle. This places every comparison exactly one rising edge after the stimulus. The model tracks frame position, lock state and the shifted bytes as plain integers. Every cycle it checks both strobes, all data fields, and whether the two strobes overlap.

// File: rtl/e1t1_map_pkg.sv
package e1t1_map_pkg;

    localparam int E1_SLOTS    = 32;
    localparam int T1_CHANS    = 24;
    localparam int SLOT_BITS   = 8;
    localparam int SIG_BITS    = 4;
    localparam int SLOT_IDX_W  = $clog2(E1_SLOTS);
    localparam int BIT_IDX_W   = $clog2(SLOT_BITS);
    localparam int FRAME_IDX_W = SLOT_IDX_W + BIT_IDX_W;
    localparam int FBIT_SLOT   = 0;

    typedef enum logic [1:0] {
        MAP_STD   = 2'd0,
        MAP_FILL4 = 2'd1,
        MAP_CONT  = 2'd2,
        MAP_RSVD  = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic                  done;
        logic [SLOT_IDX_W-1:0] slot;
        logic [SLOT_BITS-1:0]  data;
        logic [SIG_BITS-1:0]   sig;
    } slot_evt_t;

    // Only the continuous scheme is built; every other code resolves to it.
    function automatic map_mode_e resolve_mode(input logic [1:0] code);
        case (code)
            2'd2:    return MAP_CONT;
            default: return MAP_CONT;
        endcase
    endfunction

    // Timeslot to T1 channel under continuous mapping; 0 means "no channel".
    function automatic logic [SLOT_IDX_W-1:0] cont_channel(input logic [SLOT_IDX_W-1:0] slot);
        if (slot >= SLOT_IDX_W'(1) && slot <= SLOT_IDX_W'(T1_CHANS))
            return slot;
        return '0;
    endfunction

    // Frame index of the bit taken with the sync pulse.
    function automatic logic [FRAME_IDX_W-1:0] sync_index(
        input logic [SLOT_IDX_W-1:0] choff,
        input logic [BIT_IDX_W-1:0]  boff
    );
        return FRAME_IDX_W'(0) - {choff, boff};
    endfunction

endpackage

// File: rtl/e1t1_frame_pos.sv
module e1t1_frame_pos
    import e1t1_map_pkg::*;
#(
    parameter int SLOT_W = SLOT_IDX_W,
    parameter int BIT_W  = BIT_IDX_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic                    sync_in,
    input  logic [SLOT_W-1:0]       chan_off,
    input  logic [BIT_W-1:0]        bit_off,
    output logic [SLOT_W+BIT_W-1:0] cur_idx,
    output logic                    aligned,
    output logic                    locked
);
    localparam int IDX_W = SLOT_W + BIT_W;

    logic [IDX_W-1:0] pos_q;
    logic             lock_q;
    logic             take_sync;

    assign take_sync = bit_en & sync_in;
    assign cur_idx   = take_sync ? sync_index(chan_off, bit_off) : pos_q;
    assign aligned   = lock_q | take_sync;
    assign locked    = lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            lock_q <= 1'b0;
        end else if (bit_en) begin
            pos_q <= cur_idx + IDX_W'(1);
            if (take_sync)
                lock_q <= 1'b1;
        end
    end

    AST_SYNC_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (sync_in && bit_en) |=> lock_q); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(pos_q) && $stable(lock_q))); // R12

endmodule

// File: rtl/e1t1_slot_deser.sv
module e1t1_slot_deser
    import e1t1_map_pkg::*;
#(
    parameter int SLOT_W = SLOT_IDX_W,
    parameter int BIT_W  = BIT_IDX_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic                    e1_bit,
    input  logic                    e1_sig,
    input  logic [SLOT_W+BIT_W-1:0] cur_idx,
    input  logic                    aligned,
    output slot_evt_t               evt
);
    logic [SLOT_BITS-1:0] data_q;
    logic [SIG_BITS-1:0]  sig_q;
    logic [SLOT_W-1:0]    slot_q;
    logic                 done_q;
    logic                 last_bit;

    assign last_bit = (cur_idx[BIT_W-1:0] == {BIT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            sig_q  <= '0;
            slot_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= bit_en & aligned & last_bit;
            if (bit_en) begin
                data_q <= {data_q[SLOT_BITS-2:0], e1_bit};
                sig_q  <= {sig_q[SIG_BITS-2:0], e1_sig};
                slot_q <= cur_idx[SLOT_W+BIT_W-1:BIT_W];
            end
        end
    end

    assign evt = '{done: done_q, slot: slot_q, data: data_q, sig: sig_q};

    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(bit_en)); // R12

endmodule

// File: rtl/e1t1_chan_map.sv
module e1t1_chan_map
    import e1t1_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  slot_evt_t             evt,
    input  logic [1:0]            map_mode,
    input  logic                  locked,
    output logic                  ch_valid,
    output logic [SLOT_IDX_W-1:0] ch_num,
    output logic [SLOT_BITS-1:0]  ch_data,
    output logic [SIG_BITS-1:0]   ch_sig,
    output logic                  fbit_valid,
    output logic                  fbit
);
    map_mode_e             eff_mode;
    logic [SLOT_IDX_W-1:0] chan;

    always_comb begin
        eff_mode = resolve_mode(map_mode);
        case (eff_mode)
            MAP_CONT: chan = cont_channel(evt.slot);
            default:  chan = cont_channel(evt.slot);
        endcase
        ch_valid   = evt.done && (chan != '0);
        ch_num     = ch_valid ? chan : '0;
        ch_data    = ch_valid ? evt.data : '0;
        ch_sig     = ch_valid ? evt.sig : '0;
        fbit_valid = evt.done && (evt.slot == SLOT_IDX_W'(FBIT_SLOT));
        fbit       = fbit_valid & evt.data[0];
    end

    AST_CH_RANGE: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> (ch_num >= SLOT_IDX_W'(1) && ch_num <= SLOT_IDX_W'(T1_CHANS))); // R5

    AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
        (ch_valid || fbit_valid) |-> locked); // R1

    AST_TS_DROP: assert property (@(posedge clk) disable iff (rst)
        (evt.done && evt.slot > SLOT_IDX_W'(T1_CHANS)) |-> (!ch_valid && !fbit_valid)); // R7

endmodule

// File: rtl/e1t1_mapper.sv
module e1t1_mapper
    import e1t1_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       e1_bit,
    input  logic       e1_sig,
    input  logic       sync_in,
    input  logic [4:0] chan_off,
    input  logic [2:0] bit_off,
    input  logic [1:0] map_mode,
    output logic       ch_valid,
    output logic [4:0] ch_num,
    output logic [7:0] ch_data,
    output logic [3:0] ch_sig,
    output logic       fbit_valid,
    output logic       fbit
);
    logic [FRAME_IDX_W-1:0] cur_idx;
    logic                   aligned;
    logic                   locked;
    slot_evt_t              evt;

    e1t1_frame_pos #(.SLOT_W(SLOT_IDX_W), .BIT_W(BIT_IDX_W)) pos_i (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .sync_in  (sync_in),
        .chan_off (chan_off),
        .bit_off  (bit_off),
        .cur_idx  (cur_idx),
        .aligned  (aligned),
        .locked   (locked)
    );

    e1t1_slot_deser #(.SLOT_W(SLOT_IDX_W), .BIT_W(BIT_IDX_W)) deser_i (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .e1_bit  (e1_bit),
        .e1_sig  (e1_sig),
        .cur_idx (cur_idx),
        .aligned (aligned),
        .evt     (evt)
    );

    e1t1_chan_map map_i (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .map_mode   (map_mode),
        .locked     (locked),
        .ch_valid   (ch_valid),
        .ch_num     (ch_num),
        .ch_data    (ch_data),
        .ch_sig     (ch_sig),
        .fbit_valid (fbit_valid),
        .fbit       (fbit)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(ch_valid && fbit_valid)); // R11

endmodule

// File: tb/e1t1_mapper_tb.sv
module e1t1_mapper_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0, e1_bit = 1'b0, e1_sig = 1'b0, sync_in = 1'b0;
    logic [4:0] chan_off = '0;
    logic [2:0] bit_off = '0;
    logic [1:0] map_mode = 2'd2;
    logic       ch_valid, fbit_valid, fbit;
    logic [4:0] ch_num;
    logic [7:0] ch_data;
    logic [3:0] ch_sig;

    e1t1_mapper dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .e1_bit(e1_bit), .e1_sig(e1_sig),
        .sync_in(sync_in), .chan_off(chan_off), .bit_off(bit_off), .map_mode(map_mode),
        .ch_valid(ch_valid), .ch_num(ch_num), .ch_data(ch_data), .ch_sig(ch_sig),
        .fbit_valid(fbit_valid), .fbit(fbit)
    );

    always #2 clk = ~clk;

    int    n_chk = 0, n_bad = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    // behavioural reference state
    bit    m_lock = 1'b0;
    int    m_idx = 0, m_data = 0, m_sig = 0;
    int    e_cv = 0, e_num = 0, e_data = 0, e_sig = 0, e_fv = 0, e_fb = 0;
    string e_tag = "R1";

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", tag, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(int'(ch_valid) == e_cv, e_tag, "ch_valid", int'(ch_valid), e_cv);
        chk(int'(fbit_valid) == e_fv, (e_tag == "R5") ? "R4" : e_tag, "fbit_valid", int'(fbit_valid), e_fv);
        chk(int'(ch_num) == e_num, "R5", "ch_num", int'(ch_num), e_num);
        chk(int'(ch_data) == e_data, "R5", "ch_data", int'(ch_data), e_data);
        chk(int'(ch_sig) == e_sig, "R6", "ch_sig", int'(ch_sig), e_sig);
        chk(int'(fbit) == e_fb, "R4", "fbit", int'(fbit), e_fb);
        chk(!(ch_valid && fbit_valid), "R11", "both strobes", int'(ch_valid) + int'(fbit_valid), 1);
    endtask

    // One cycle: check outputs due now, drive new inputs, predict next outputs.
    task automatic step(bit r, bit en, bit b, bit s, bit sy);
        @(negedge clk);
        compare();
        rst = r; bit_en = en; e1_bit = b; e1_sig = s; sync_in = sy;
        e_cv = 0; e_num = 0; e_data = 0; e_sig = 0; e_fv = 0; e_fb = 0;
        if (r) begin
            m_lock = 1'b0; m_idx = 0; m_data = 0; m_sig = 0; e_tag = "R1";
        end else begin
            e_tag = !m_lock ? "R1" : (!en ? "R12" : "R3");
            if (en) begin
                if (sy) begin
                    m_idx  = (256 - (int'(chan_off) * 8 + int'(bit_off))) % 256;
                    m_lock = 1'b1;
                end
                m_data = ((m_data << 1) | int'(b)) & 255;
                m_sig  = ((m_sig << 1) | int'(s)) & 15;
                if (m_lock && (m_idx % 8) == 7) begin
                    if (m_idx / 8 == 0) begin
                        e_fv = 1; e_fb = int'(b); e_tag = "R4";
                    end else if (m_idx / 8 <= 24) begin
                        e_cv = 1; e_num = m_idx / 8; e_data = m_data; e_sig = m_sig; e_tag = "R5";
                    end else begin
                        e_tag = "R7";
                    end
                end
                m_idx = (m_idx + 1) % 256;
            end
        end
    endtask

    // Strobes with random gaps; sync on every sync_every-th strobe (0: never).
    task automatic run_bits(int nstrobes, int en_pct, int sync_every,
                            int choff, int boff, int mode, string ph);
        int k;
        phase = ph; chan_off = 5'(choff); bit_off = 3'(boff); map_mode = 2'(mode);
        k = 0;
        while (k < nstrobes) begin
            bit en, sy;
            en = (($urandom % 100) < en_pct);
            if (en) begin
                sy = (sync_every > 0) && (k % sync_every == 0);
                k++;
            end else begin
                sy = 1'($urandom % 2);   // unqualified sync noise (R2)
            end
            step(1'b0, en, 1'($urandom % 2), 1'($urandom % 2), sy);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // reset state, R1
        phase = "R1";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_bits(400, 80, 0, 0, 0, 2, "R1");
        // R2: sync without strobe must not lock
        phase = "R2";
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'($urandom % 2), 1'($urandom % 2), 1'b1);
        run_bits(300, 100, 0, 0, 0, 2, "R2");
        // zero offset, full rate, then free-running cadence R8
        run_bits(768, 100, 256, 0, 0, 2, "R5");
        run_bits(600, 100, 0, 0, 0, 2, "R8");
        // offsets R3, including the largest
        run_bits(700, 70, 256, 3, 5, 2, "R3");
        run_bits(700, 85, 256, 31, 7, 2, "R3");
        run_bits(600, 100, 256, 0, 7, 2, "R3");
        // mid-frame realignment R9
        run_bits(100, 100, 256, 0, 0, 2, "R9");
        run_bits(600, 100, 256, 2, 1, 2, "R9");
        run_bits(37, 100, 256, 5, 3, 2, "R9");
        run_bits(600, 90, 0, 5, 3, 2, "R9");
        // every mode code maps continuously, R10
        for (int m = 0; m < 4; m++) run_bits(560, 90, 256, 1, 2, m, "R10");
        // sparse strobes, R12
        run_bits(600, 30, 256, 4, 4, 2, "R12");
        // reset mid-stream returns to unlocked, R1
        phase = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        run_bits(300, 100, 0, 0, 0, 2, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule